// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

This block runs one machine cycle at a time on an external bus. The low address byte and the data byte share one 8-bit port, and the high address byte has a port of its own. A requester asks for one of five cycle kinds: memory read, memory write, I/O read, I/O write or opcode fetch. The controller then steps through T1, T2, optional wait states and T3. It drives the address strobe, the I/O-versus-memory line, two status bits and the active-low read and write strobes.

In T1 the shared port carries the low address and ALE pulses so that an external latch can capture it. In T2 and T3 the same port carries data. A slow device holds READY low to stretch the cycle. Another bus master can take the bus with HOLD. The controller grants it with HLDA, but only between machine cycles, and it releases every driver while the grant is active. Every pin comes out as a separate output value, output enable and input; no pin is tristate.

A request is offered with `req_valid_i`. It is taken on a clock edge where the controller is idle or finishing T3, HOLD is low and the kind is legal. The next cycle is T1, which the ALE pulse makes visible.

Top module: `mux_bus_ctrl`

## Requirements
- R1: A taken request makes the next cycle T1. ALE is high during T1 and in no other cycle. A request is taken only on an edge where the controller is idle or in T3 and `hold_i` is low.
- R2: In T1 the shared port drives `req_addr_i[7:0]` with its enable high. For writes it drives the write data with the enable high from T2 through T3. For reads and fetches the enable is low from T2 through T3.
- R3: For reads and fetches, `ad_i` is sampled at the end of T3. In the following cycle, `rdata_o` shows that byte and `done_o` is high for exactly one cycle. For writes, `done_o` pulses in that same following cycle.
- R4: During T1 to T3, `addr_hi_o` carries `req_addr_i[15:8]` for memory cycles. For I/O cycles it carries the 8-bit port number `req_addr_i[7:0]`.
- R5: During T1 to T3, `io_m_o` is 1 for I/O cycles and 0 for memory cycles, and it does not change within a cycle.
- R6: The status bits {`s1_o`,`s0_o`} are 11 for an opcode fetch, 10 for a memory or I/O read, and 01 for a memory or I/O write. They are 00 outside a machine cycle.
- R7: For reads and fetches, `rd_n_o` is low from T2 through T3. For writes, `wr_n_o` is low over the same span. The two strobes are never low together, and both are high at all other times.
- R8: `ready_i` is sampled in T2 and in every wait state. Each low sample inserts one more wait state, during which the strobes and the data drive are held. `ready_i` has no effect in T1 or T3.
- R9: When `hold_i` is high at a cycle boundary (idle or the end of T3), `hlda_o` rises on the next cycle. A hold raised during T1, T2 or a wait state does not cut the cycle short.
- R10: While `hlda_o` is high, all output enables (`ad_oe_o`, `addr_hi_oe_o`, `ctrl_oe_o`) are low and requests are not taken. `hlda_o` falls on the edge after `hold_i` goes low, and a pending request starts on the edge after that.
- R11: Kind codes on `req_kind_i` are 0 memory read, 1 memory write, 2 I/O read, 3 I/O write and 4 opcode fetch. Codes 5 to 7 are never taken and start no cycle.
- R12: After reset the controller is idle. ALE, `hlda_o`, `done_o` and `ad_oe_o` are low, both strobes are high, and `addr_hi_oe_o` and `ctrl_oe_o` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Cycle request offered |
| req_kind_i | input | 3 | Cycle kind code |
| req_addr_i | input | 16 | Cycle address |
| req_wdata_i | input | 8 | Write data |
| done_o | output | 1 | One-cycle pulse after T3 |
| rdata_o | output | 8 | Byte captured at end of T3 |
| ad_o | output | 8 | Shared address/data port, value out |
| ad_oe_o | output | 1 | Shared port output enable |
| ad_i | input | 8 | Shared address/data port, value in |
| addr_hi_o | output | 8 | High address / I/O port number |
| addr_hi_oe_o | output | 1 | High address enable |
| ale_o | output | 1 | Address latch strobe |
| io_m_o | output | 1 | 1 = I/O cycle, 0 = memory cycle |
| s1_o | output | 1 | Status bit 1 |
| s0_o | output | 1 | Status bit 0 |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| ctrl_oe_o | output | 1 | Enable for io_m, rd_n, wr_n |
| ready_i | input | 1 | Device ready; low stretches the cycle |
| hold_i | input | 1 | Bus request from another master |
| hlda_o | output | 1 | Bus grant |

## Verification
A vector table runs all five cycle kinds with wait counts of zero, one and three. This separates the memory and I/O decoding of the high address byte, the three status codes, and the read versus write use of the shared port, and it shows that each low READY sample adds exactly one cycle. Directed runs cover the cases the table cannot express:
- illegal kind codes;
- HOLD raised while idle and while a cycle is in flight, which tells a boundary-only grant from an immediate one;
- a request held through HOLD, which shows when it starts once the bus is released;
- back-to-back cycles, where T3 moves straight into the next T1.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  typedef enum logic [2:0] {
    K_MRD   = 3'd0,
    K_MWR   = 3'd1,
    K_IORD  = 3'd2,
    K_IOWR  = 3'd3,
    K_FETCH = 3'd4
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_T1, ST_T2, ST_TW, ST_T3, ST_HOLD
  } state_e;

  typedef struct packed {
    logic is_io;
    logic is_wr;
    logic is_fetch;
  } cyc_attr_t;

  function automatic logic kind_legal(logic [2:0] k);
    return k <= 3'd4;
  endfunction

  function automatic cyc_attr_t decode_kind(logic [2:0] k);
    cyc_attr_t a;
    a.is_io    = (k == K_IORD) || (k == K_IOWR);
    a.is_wr    = (k == K_MWR)  || (k == K_IOWR);
    a.is_fetch = (k == K_FETCH);
    return a;
  endfunction
endpackage

// File: rtl/mbc_seq.sv
module mbc_seq
  import mbc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   hold_i,
  input  logic   ready_i,
  output state_e state_o,
  output logic   take_o,
  output logic   t3_exit_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (hold_i) state_d = ST_HOLD;
               else if (start_i) state_d = ST_T1;
      ST_T1:   state_d = ST_T2;
      ST_T2,
      ST_TW:   state_d = ready_i ? ST_T3 : ST_TW;
      ST_T3:   if (hold_i) state_d = ST_HOLD;
               else if (start_i) state_d = ST_T1;
               else state_d = ST_IDLE;
      ST_HOLD: if (!hold_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o   = state_q;
  assign take_o    = (state_d == ST_T1);
  assign t3_exit_o = (state_q == ST_T3);
endmodule

// File: rtl/mbc_req_reg.sv
module mbc_req_reg
  import mbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              t3_exit_i,
  input  logic [2:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] ad_i,
  output cyc_attr_t         attr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  cyc_attr_t         attr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      attr_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (take_i) begin
      attr_q  <= decode_kind(kind_i);
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= t3_exit_i;
      if (t3_exit_i && !attr_q.is_wr) rdata_q <= ad_i;
    end
  end

  assign attr_o  = attr_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign rdata_o = rdata_q;
  assign done_o  = done_q;
endmodule

// File: rtl/mbc_drive.sv
module mbc_drive
  import mbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  state_e                   state_i,
  input  cyc_attr_t                attr_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe_o,
  output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
  output logic                     addr_hi_oe_o,
  output logic                     ale_o,
  output logic                     io_m_o,
  output logic                     s1_o,
  output logic                     s0_o,
  output logic                     rd_n_o,
  output logic                     wr_n_o,
  output logic                     ctrl_oe_o,
  output logic                     hlda_o
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic t1, strobe, active, owned;
  assign t1     = (state_i == ST_T1);
  assign strobe = (state_i == ST_T2) || (state_i == ST_TW) || (state_i == ST_T3);
  assign active = t1 || strobe;
  assign owned  = (state_i != ST_HOLD);

  assign ale_o   = t1;
  assign ad_o    = t1 ? addr_i[DATA_W-1:0] : wdata_i;
  assign ad_oe_o = t1 || (strobe && attr_i.is_wr);

  // I/O cycles mirror the port number onto the high byte
  generate
    if (HI_W <= DATA_W) begin : g_hi_narrow
      assign addr_hi_o = attr_i.is_io ? addr_i[HI_W-1:0] : addr_i[ADDR_W-1:DATA_W];
    end else begin : g_hi_wide
      assign addr_hi_o = attr_i.is_io ? {{(HI_W-DATA_W){1'b0}}, addr_i[DATA_W-1:0]}
                                      : addr_i[ADDR_W-1:DATA_W];
    end
  endgenerate

  assign io_m_o = active && attr_i.is_io;
  assign s1_o   = active && !attr_i.is_wr;
  assign s0_o   = active && (attr_i.is_wr || attr_i.is_fetch);
  assign rd_n_o = !(strobe && !attr_i.is_wr);
  assign wr_n_o = !(strobe && attr_i.is_wr);

  assign addr_hi_oe_o = owned;
  assign ctrl_oe_o    = owned;
  assign hlda_o       = !owned;
endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic [2:0]               req_kind_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic [DATA_W-1:0]        req_wdata_i,
  output logic                     done_o,
  output logic [DATA_W-1:0]        rdata_o,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe_o,
  input  logic [DATA_W-1:0]        ad_i,
  output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
  output logic                     addr_hi_oe_o,
  output logic                     ale_o,
  output logic                     io_m_o,
  output logic                     s1_o,
  output logic                     s0_o,
  output logic                     rd_n_o,
  output logic                     wr_n_o,
  output logic                     ctrl_oe_o,
  input  logic                     ready_i,
  input  logic                     hold_i,
  output logic                     hlda_o
);
  state_e            state;
  logic              take, t3_exit, start;
  cyc_attr_t         attr;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign start = req_valid_i && kind_legal(req_kind_i);

  mbc_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .hold_i    (hold_i),
    .ready_i   (ready_i),
    .state_o   (state),
    .take_o    (take),
    .t3_exit_o (t3_exit)
  );

  mbc_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (take),
    .t3_exit_i (t3_exit),
    .kind_i    (req_kind_i),
    .addr_i    (req_addr_i),
    .wdata_i   (req_wdata_i),
    .ad_i      (ad_i),
    .attr_o    (attr),
    .addr_o    (addr_q),
    .wdata_o   (wdata_q),
    .rdata_o   (rdata_o),
    .done_o    (done_o)
  );

  mbc_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
    .state_i      (state),
    .attr_i       (attr),
    .addr_i       (addr_q),
    .wdata_i      (wdata_q),
    .ad_o         (ad_o),
    .ad_oe_o      (ad_oe_o),
    .addr_hi_o    (addr_hi_o),
    .addr_hi_oe_o (addr_hi_oe_o),
    .ale_o        (ale_o),
    .io_m_o       (io_m_o),
    .s1_o         (s1_o),
    .s0_o         (s0_o),
    .rd_n_o       (rd_n_o),
    .wr_n_o       (wr_n_o),
    .ctrl_oe_o    (ctrl_oe_o),
    .hlda_o       (hlda_o)
  );
endmodule

// File: rtl/mbc_checker.sv
module mbc_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic hold_i,
  input logic ready_i,
  input logic ale_o,
  input logic ad_oe_o,
  input logic addr_hi_oe_o,
  input logic ctrl_oe_o,
  input logic io_m_o,
  input logic s1_o,
  input logic s0_o,
  input logic rd_n_o,
  input logic wr_n_o,
  input logic hlda_o,
  input logic done_o
);
  assert_ale_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);

  assert_read_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_o && s1_o) |=> !rd_n_o);

  assert_write_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_o && !s1_o && s0_o) |=> !wr_n_o);

  assert_strobe_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o));

  assert_io_m_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> $stable(io_m_o));

  assert_no_wait_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rd_n_o) && ready_i) |=> (!rd_n_o ##1 rd_n_o));

  assert_wait_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rd_n_o) && !ready_i) |=> (!rd_n_o ##1 !rd_n_o));

  assert_grant_float_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> (!ad_oe_o && !addr_hi_oe_o && !ctrl_oe_o && !ale_o));

  assert_grant_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hlda_o && !hold_i) |=> !hlda_o);

  assert_grant_boundary_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_o || !wr_n_o || ale_o) |-> !hlda_o);

  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind mux_bus_ctrl mbc_checker u_mbc_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .hold_i       (hold_i),
  .ready_i      (ready_i),
  .ale_o        (ale_o),
  .ad_oe_o      (ad_oe_o),
  .addr_hi_oe_o (addr_hi_oe_o),
  .ctrl_oe_o    (ctrl_oe_o),
  .io_m_o       (io_m_o),
  .s1_o         (s1_o),
  .s0_o         (s0_o),
  .rd_n_o       (rd_n_o),
  .wr_n_o       (wr_n_o),
  .hlda_o       (hlda_o),
  .done_o       (done_o)
);

// File: tb/mux_bus_ctrl_bench.sv
module mux_bus_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int NV = 8;
  // {kind[3], addr[16], wdata[8], rdata[8], waits[4]}
  localparam logic [38:0] VEC [NV] = '{
    {3'd0, 16'h12A5, 8'h00, 8'h3C, 4'd0},
    {3'd1, 16'hBEEF, 8'h5A, 8'h00, 4'd0},
    {3'd2, 16'h0077, 8'h00, 8'hC3, 4'd1},
    {3'd3, 16'h9A42, 8'hE1, 8'h00, 4'd0},
    {3'd4, 16'h8001, 8'h00, 8'h96, 4'd3},
    {3'd0, 16'hFF00, 8'h00, 8'hFF, 4'd1},
    {3'd1, 16'h0000, 8'hA7, 8'h00, 4'd3},
    {3'd4, 16'h4321, 8'h00, 8'h01, 4'd0}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, ready = 1'b1, hold = 1'b0;
  logic [2:0]  req_kind = '0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, ad_in = '0;
  logic        done, ad_oe, addr_hi_oe, ale, io_m, s1, s0, rd_n, wr_n, ctrl_oe, hlda;
  logic [7:0]  rdata, ad_out, addr_hi;
  int          n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  mux_bus_ctrl u_mux_bus_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_kind_i(req_kind),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .done_o(done), .rdata_o(rdata),
    .ad_o(ad_out), .ad_oe_o(ad_oe), .ad_i(ad_in), .addr_hi_o(addr_hi),
    .addr_hi_oe_o(addr_hi_oe), .ale_o(ale), .io_m_o(io_m), .s1_o(s1), .s0_o(s0),
    .rd_n_o(rd_n), .wr_n_o(wr_n), .ctrl_oe_o(ctrl_oe), .ready_i(ready),
    .hold_i(hold), .hlda_o(hlda)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic run_cycle(input logic [2:0] k, input logic [15:0] a, input logic [7:0] wd,
                           input logic [7:0] rd, input int waits);
    bit is_io, is_wr;
    logic [1:0] st;
    logic [7:0] hi;
    is_io = (k == 3'd2) || (k == 3'd3);
    is_wr = (k == 3'd1) || (k == 3'd3);
    st    = (k == 3'd4) ? 2'b11 : (is_wr ? 2'b01 : 2'b10);
    hi    = is_io ? a[7:0] : a[15:8];
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd; ready = 1'b1;
    step();
    req_valid = 1'b0;
    // T1
    chk(ale == 1'b1, "R1 ale in T1", ale, 1);
    chk(ad_oe && ad_out == a[7:0], "R2 low addr in T1", {ad_oe, ad_out}, {1'b1, a[7:0]});
    chk(addr_hi == hi, "R4 high byte", addr_hi, hi);
    chk(io_m == is_io, "R5 io_m", io_m, is_io);
    chk({s1, s0} == st, "R6 status", {s1, s0}, st);
    chk(rd_n && wr_n, "R7 no strobe in T1", {rd_n, wr_n}, 2'b11);
    ready = (waits == 0);
    step();
    // T2
    chk(ale == 1'b0, "R1 ale low in T2", ale, 0);
    chk({rd_n, wr_n} == (is_wr ? 2'b10 : 2'b01), "R7 strobe in T2", {rd_n, wr_n},
        is_wr ? 2'b10 : 2'b01);
    if (is_wr) chk(ad_oe && ad_out == wd, "R2 write data T2", {ad_oe, ad_out}, {1'b1, wd});
    else       chk(!ad_oe, "R2 port released T2", ad_oe, 0);
    for (int i = 0; i < waits; i++) begin
      step();
      chk({rd_n, wr_n} == (is_wr ? 2'b10 : 2'b01), "R8 strobe held in wait", {rd_n, wr_n},
          is_wr ? 2'b10 : 2'b01);
      chk(!ale && !done, "R8 wait state", {ale, done}, 0);
      ready = (i + 1 >= waits);
    end
    step();
    // T3: ready is don't-care here
    chk({rd_n, wr_n} == (is_wr ? 2'b10 : 2'b01), "R7 strobe in T3", {rd_n, wr_n},
        is_wr ? 2'b10 : 2'b01);
    chk(!done, "R3 no done in T3", done, 0);
    chk({s1, s0} == st, "R6 status in T3", {s1, s0}, st);
    ad_in = rd; ready = 1'b0;
    step();
    chk(done == 1'b1, "R3 done after T3", done, 1);
    chk(rd_n && wr_n && !ale, "R7 strobes idle", {rd_n, wr_n, ale}, 3'b110);
    chk({s1, s0} == 2'b00, "R6 idle status", {s1, s0}, 0);
    if (!is_wr) chk(rdata == rd, "R3 read data", rdata, rd);
    ready = 1'b1;
    step();
    chk(!done, "R3 done one cycle", done, 0);
  endtask

  initial begin
    #(CLK_P * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(!ale && !hlda && !done && !ad_oe, "R12 reset outputs", {ale, hlda, done, ad_oe}, 0);
    chk(rd_n && wr_n && addr_hi_oe && ctrl_oe, "R12 reset strobes/enables",
        {rd_n, wr_n, addr_hi_oe, ctrl_oe}, 4'hF);

    for (int v = 0; v < NV; v++)
      run_cycle(VEC[v][38:36], VEC[v][35:20], VEC[v][19:12], VEC[v][11:4], int'(VEC[v][3:0]));

    // R11 illegal kinds ignored
    for (int k = 5; k < 8; k++) begin
      req_valid = 1'b1; req_kind = 3'(k);
      step(); step();
      chk(!ale && rd_n && wr_n, "R11 illegal kind ignored", {ale, rd_n, wr_n}, 3'b011);
    end
    req_valid = 1'b0;

    // R9/R10 hold while idle, request pending
    hold = 1'b1; req_valid = 1'b1; req_kind = 3'd0; req_addr = 16'h5566;
    step();
    chk(hlda, "R9 grant from idle", hlda, 1);
    chk(!ad_oe && !addr_hi_oe && !ctrl_oe, "R10 drivers off", {ad_oe, addr_hi_oe, ctrl_oe}, 0);
    step();
    chk(hlda && !ale, "R10 request not taken in hold", {hlda, ale}, 2'b10);
    hold = 1'b0;
    step();
    chk(!hlda && !ale, "R10 grant drops", {hlda, ale}, 0);
    step();
    chk(ale && ad_out == 8'h66, "R10 pending request starts", {ale, ad_out}, {1'b1, 8'h66});
    req_valid = 1'b0;
    step(); step(); step();

    // R9 hold mid-cycle: cycle completes first
    req_valid = 1'b1; req_kind = 3'd1; req_addr = 16'h1234; req_wdata = 8'h77;
    step();
    req_valid = 1'b0;
    chk(ale, "R1 start for hold test", ale, 1);
    hold = 1'b1;
    step();
    chk(!hlda && !wr_n, "R9 no grant in T2", {hlda, wr_n}, 2'b00);
    step();
    chk(!hlda && !wr_n, "R9 no grant in T3", {hlda, wr_n}, 2'b00);
    step();
    chk(hlda && done, "R9 grant after T3", {hlda, done}, 2'b11);
    hold = 1'b0;
    step();
    chk(!hlda, "R10 release", hlda, 0);

    // R1 back-to-back: T3 goes straight to next T1
    req_valid = 1'b1; req_kind = 3'd2; req_addr = 16'h00AB;
    step();
    chk(ale, "R1 b2b first T1", ale, 1);
    step(); step();
    chk(!rd_n, "R1 b2b T3", rd_n, 0);
    step();
    chk(ale && done, "R1 b2b next T1 after T3", {ale, done}, 2'b11);
    req_valid = 1'b0;
    step(); step(); step(); step();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule